// File: doc/BRIEF.md
# Parallel Channel Destination Receiver

This block is the receiving end of a parallel point-to-point data channel. It watches the forward lines: a connection request, a packet frame, a burst frame and a word bus with one parity bit per byte. It drives the reverse lines back to the sender: a connection grant and single-cycle flow-control credits. The host decides whether a pending request is accepted. When the block grants a request, it keeps the word that was present with the request as the I-field. It then hands out one credit for each burst-sized slot of free room that the host reports in its FIFO.

While connected, every word framed by both packet and burst goes straight to the host FIFO through a write strobe, together with its parity bits. The word that follows the end of a burst is the check word. It is compared with the XOR of that burst's words and is not written to the FIFO. Byte parity faults and check word mismatches set sticky status flags, which a new grant clears. A self-test input pulls the link-present output low and forces the block off the channel.

Top module: `pcd_receiver`

## Requirements
- R1: `link_o` is the inverse of `selftest_i`. While `selftest_i` is high, no grant is made, and a live connection is dropped: `conn_o` is low one cycle after `selftest_i` is seen high.
- R2: In the idle state, a cycle with `req_i`, `accept_en_i` high and `selftest_i` low raises `conn_o` one cycle later, and `ifield_o` then holds the `data_i` of that cycle. A request without `accept_en_i` is ignored: `conn_o` stays low and `ifield_o` keeps its value.
- R3: A cycle with `conn_o` high and `req_i` low makes `conn_o` low one cycle later.
- R4: While connected, credits (`rdy_o` high for one cycle per credit) are issued until the number outstanding equals min(MAX_CREDIT, floor(`fifo_free_i` / SLOT_WORDS)). The outstanding count restarts at zero on every new connection.
- R5: The number of credits outstanding never exceeds MAX_CREDIT, however much room the FIFO reports.
- R6: A word sampled while `conn_o`, `pkt_i` and `bst_i` are all high appears on `fifo_data_o`/`fifo_par_o` with `fifo_wr_o` high one cycle later. No other word is written.
- R7: Parity is odd per byte. `par_i[k]` covers `data_i[8k+7:8k]`, and the byte plus its bit must hold an odd number of ones. A failing captured word sets `par_err_o` one cycle later and is still written. The flag stays set.
- R8: The word in the first cycle with `bst_i` low after a captured word is the check word. It is not written. If it differs from the XOR of the burst's words, `llrc_err_o` is set one cycle later and stays set.
- R9: A grant clears both `par_err_o` and `llrc_err_o`.
- R10: The end of each burst returns one outstanding credit, so that room still reported by the FIFO produces one new credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Connection request from the sender |
| pkt_i | input | 1 | Packet frame |
| bst_i | input | 1 | Burst frame |
| data_i | input | DATA_W | Forward word bus |
| par_i | input | DATA_W/8 | Odd parity, one bit per byte |
| accept_en_i | input | 1 | Host permits granting a request |
| selftest_i | input | 1 | Self-test: leave the channel |
| fifo_free_i | input | FREE_W | Free words in the host FIFO |
| conn_o | output | 1 | Connection grant to the sender |
| rdy_o | output | 1 | One-cycle burst credit |
| link_o | output | 1 | Link-present line, low in self-test |
| ifield_o | output | DATA_W | Word captured at grant |
| fifo_wr_o | output | 1 | Host FIFO write strobe |
| fifo_data_o | output | DATA_W | Word to host FIFO |
| fifo_par_o | output | DATA_W/8 | Parity to host FIFO |
| par_err_o | output | 1 | Sticky byte parity fault |
| llrc_err_o | output | 1 | Sticky check word mismatch |

## Verification
Grant, drop, FIFO write and both error flags are all registered one edge after the input that causes them. The bench drives one input cycle per clock and compares these results on the following clock, one nanosecond after the edge. A credit needs two edges: the count updates, then the next pulse is decided. For that reason credits are counted over a window of many cycles after each stimulus, never at one chosen cycle. The number of free slots is swept across and past the credit limit, and the parity fault is placed in each byte lane in turn.

// File: rtl/pcd_pkg.sv
// Shared types for the parallel channel destination receiver.
package pcd_pkg;
    typedef enum logic {
        LNK_IDLE = 1'b0,
        LNK_UP   = 1'b1
    } lnk_state_t;
endpackage

// File: rtl/pcd_link_ctrl.sv
// Connection control: decides grants, keeps the I-field word and drops the
// connection on request withdrawal or self-test.
// Assumes the request line is already synchronous to clk.
module pcd_link_ctrl #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              accept_en_i,
    input  logic              selftest_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              conn_o,
    output logic              grant_o,
    output logic              live_o,
    output logic              link_o,
    output logic [DATA_W-1:0] ifield_o
);
    import pcd_pkg::*;

    lnk_state_t state_q;

    // Grant only from idle, with host consent and outside self-test.
    always_comb begin
        grant_o = (state_q == LNK_IDLE) && req_i && accept_en_i && !selftest_i;
        conn_o  = (state_q == LNK_UP);
        live_o  = conn_o && req_i && !selftest_i;
        link_o  = !selftest_i;
    end

    // Connection state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LNK_IDLE;
        end else begin
            case (state_q)
                LNK_IDLE: if (grant_o) state_q <= LNK_UP;
                LNK_UP:   if (!req_i || selftest_i) state_q <= LNK_IDLE;
                default:  state_q <= LNK_IDLE;
            endcase
        end
    end

    // I-field register, loaded at the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) ifield_o <= '0;
        else if (grant_o) ifield_o <= data_i;
    end

    p_no_grant_without_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!conn_o && !(req_i && accept_en_i)) |=> !conn_o);
    p_drop_on_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_o && !req_i) |=> !conn_o);
    p_selftest_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        selftest_i |=> !conn_o);
endmodule

// File: rtl/pcd_credit.sv
// Credit issue: keeps the count of outstanding burst credits and issues one
// READY pulse per free burst slot, up to a fixed ceiling.
// Assumes fifo_free_i counts free words and is updated by the host.
module pcd_credit #(
    parameter int FREE_W     = 16,
    parameter int SLOT_WORDS = 256,
    parameter int MAX_CREDIT = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              live_i,
    input  logic              burst_end_i,
    input  logic [FREE_W-1:0] fifo_free_i,
    output logic              rdy_o
);
    localparam int SLOT_LG = $clog2(SLOT_WORDS);
    localparam int CRED_W  = $clog2(MAX_CREDIT + 1);
    localparam int CMP_W   = (FREE_W > CRED_W) ? FREE_W : CRED_W;

    logic [CRED_W-1:0] cred_q;
    logic [CMP_W-1:0]  slots;
    logic [CMP_W-1:0]  cred_ext;
    logic              issue;
    logic              retire;

    // Decide whether another credit fits under both the room and the ceiling.
    always_comb begin
        slots    = CMP_W'(fifo_free_i >> SLOT_LG);
        cred_ext = CMP_W'(cred_q);
        retire   = burst_end_i && (cred_q != '0);
        issue    = live_i && (cred_q < CRED_W'(MAX_CREDIT)) && (cred_ext < slots);
    end

    // Outstanding count and registered credit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cred_q <= '0;
            rdy_o  <= 1'b0;
        end else if (!live_i) begin
            cred_q <= '0;
            rdy_o  <= 1'b0;
        end else begin
            cred_q <= cred_q + CRED_W'(issue) - CRED_W'(retire);
            rdy_o  <= issue;
        end
    end

    p_cred_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cred_q <= CRED_W'(MAX_CREDIT));
    p_no_pulse_at_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cred_q == CRED_W'(MAX_CREDIT) && !burst_end_i) |=> !rdy_o);
endmodule

// File: rtl/pcd_burst_rx.sv
// Burst receiver: writes framed words to the host FIFO, checks byte parity and
// compares the trailing check word with the running XOR of the burst.
// Assumes bursts arrive only inside a packet on a live connection.
module pcd_burst_rx #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  conn_i,
    input  logic                  grant_i,
    input  logic                  pkt_i,
    input  logic                  bst_i,
    input  logic [DATA_W-1:0]     data_i,
    input  logic [DATA_W/8-1:0]   par_i,
    output logic                  burst_end_o,
    output logic                  fifo_wr_o,
    output logic [DATA_W-1:0]     fifo_data_o,
    output logic [DATA_W/8-1:0]   fifo_par_o,
    output logic                  par_err_o,
    output logic                  llrc_err_o
);
    localparam int NB = DATA_W / 8;

    logic              take;
    logic              bst_q;
    logic [NB-1:0]     lane_ok;
    logic [DATA_W-1:0] acc_q;

    // Per-byte odd parity test.
    for (genvar k = 0; k < NB; k++) begin : g_lane
        assign lane_ok[k] = ^{data_i[8*k +: 8], par_i[k]};
    end

    // Capture and end-of-burst qualifiers.
    always_comb begin
        take        = conn_i && pkt_i && bst_i;
        burst_end_o = conn_i && bst_q && !bst_i;
    end

    // FIFO write path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr_o   <= 1'b0;
            fifo_data_o <= '0;
            fifo_par_o  <= '0;
        end else begin
            fifo_wr_o <= take;
            if (take) begin
                fifo_data_o <= data_i;
                fifo_par_o  <= par_i;
            end
        end
    end

    // Burst tracking and running check word.
    always_ff @(posedge clk) begin
        if (!rst_n || grant_i) begin
            bst_q <= 1'b0;
            acc_q <= '0;
        end else begin
            bst_q <= take;
            if (burst_end_o) acc_q <= '0;
            else if (take)   acc_q <= acc_q ^ data_i;
        end
    end

    // Sticky error flags, cleared on a new grant.
    always_ff @(posedge clk) begin
        if (!rst_n || grant_i) begin
            par_err_o  <= 1'b0;
            llrc_err_o <= 1'b0;
        end else begin
            if (take && !(&lane_ok)) par_err_o <= 1'b1;
            if (burst_end_o && (acc_q != data_i)) llrc_err_o <= 1'b1;
        end
    end

    p_check_word_not_written_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end_o |=> !fifo_wr_o);
    p_par_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err_o && !grant_i) |=> par_err_o);
    p_llrc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (llrc_err_o && !grant_i) |=> llrc_err_o);
    p_grant_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |=> (!par_err_o && !llrc_err_o));
endmodule

// File: rtl/pcd_receiver.sv
// Top of the parallel channel destination receiver: joins connection control,
// credit issue and burst reception.
// Assumes all channel inputs are synchronous to clk.
module pcd_receiver #(
    parameter int DATA_W     = 32,
    parameter int FREE_W     = 16,
    parameter int SLOT_WORDS = 256,
    parameter int MAX_CREDIT = 63
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic                pkt_i,
    input  logic                bst_i,
    input  logic [DATA_W-1:0]   data_i,
    input  logic [DATA_W/8-1:0] par_i,
    input  logic                accept_en_i,
    input  logic                selftest_i,
    input  logic [FREE_W-1:0]   fifo_free_i,
    output logic                conn_o,
    output logic                rdy_o,
    output logic                link_o,
    output logic [DATA_W-1:0]   ifield_o,
    output logic                fifo_wr_o,
    output logic [DATA_W-1:0]   fifo_data_o,
    output logic [DATA_W/8-1:0] fifo_par_o,
    output logic                par_err_o,
    output logic                llrc_err_o
);
    logic grant;
    logic live;
    logic burst_end;

    pcd_link_ctrl #(.DATA_W(DATA_W)) u_link (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .accept_en_i(accept_en_i),
        .selftest_i(selftest_i), .data_i(data_i), .conn_o(conn_o),
        .grant_o(grant), .live_o(live), .link_o(link_o), .ifield_o(ifield_o)
    );

    pcd_credit #(.FREE_W(FREE_W), .SLOT_WORDS(SLOT_WORDS), .MAX_CREDIT(MAX_CREDIT)) u_credit (
        .clk(clk), .rst_n(rst_n), .live_i(live), .burst_end_i(burst_end),
        .fifo_free_i(fifo_free_i), .rdy_o(rdy_o)
    );

    pcd_burst_rx #(.DATA_W(DATA_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .conn_i(conn_o), .grant_i(grant),
        .pkt_i(pkt_i), .bst_i(bst_i), .data_i(data_i), .par_i(par_i),
        .burst_end_o(burst_end), .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o),
        .fifo_par_o(fifo_par_o), .par_err_o(par_err_o), .llrc_err_o(llrc_err_o)
    );

    p_credit_only_connected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> conn_o);
    p_write_only_connected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |-> $past(conn_o));
endmodule

// File: tb/pcd_receiver_test.sv
module pcd_receiver_test;
    localparam int DW = 32;
    localparam int NB = DW / 8;
    localparam int SW = 4;
    localparam int MC = 5;
    localparam int FW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 0, pkt = 0, bst = 0, acc_en = 0, stest = 0;
    logic [DW-1:0] data = '0;
    logic [NB-1:0] par = '0;
    logic [FW-1:0] free = '0;
    logic conn, rdy, link, fwr, perr, lerr;
    logic [DW-1:0] ifield, fdata;
    logic [NB-1:0] fpar;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    pcd_receiver #(.DATA_W(DW), .FREE_W(FW), .SLOT_WORDS(SW), .MAX_CREDIT(MC)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .pkt_i(pkt), .bst_i(bst),
        .data_i(data), .par_i(par), .accept_en_i(acc_en), .selftest_i(stest),
        .fifo_free_i(free), .conn_o(conn), .rdy_o(rdy), .link_o(link),
        .ifield_o(ifield), .fifo_wr_o(fwr), .fifo_data_o(fdata),
        .fifo_par_o(fpar), .par_err_o(perr), .llrc_err_o(lerr)
    );

    function automatic logic [NB-1:0] odd_par(input logic [DW-1:0] w);
        logic [NB-1:0] p;
        for (int k = 0; k < NB; k++) p[k] = ~^w[8*k +: 8];
        return p;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic count_rdy(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (rdy) c++;
        end
    endtask

    task automatic connect(input logic [DW-1:0] iw);
        req = 1; acc_en = 1; data = iw;
        tick();
        acc_en = 0; data = '0;
    endtask

    task automatic release_link();
        req = 0; pkt = 0; bst = 0;
        tick(); tick();
    endtask

    // Sends a burst of n words from seed, then the check word (corrupted if bad_ck).
    task automatic burst(input int n, input logic [DW-1:0] seed, input logic bad_ck);
        logic [DW-1:0] x = '0;
        pkt = 1;
        for (int i = 0; i < n; i++) begin
            data = seed * (i + 3) + 32'h0101_0101 * i;
            par = odd_par(data);
            x ^= data;
            bst = 1;
            tick();
            chk("R6 write strobe", {31'b0, fwr}, 1);
            chk("R6 write data", fdata, data);
        end
        bst = 0;
        data = bad_ck ? ~x : x;
        par = odd_par(data);
        tick();
        chk("R8 check word not written", {31'b0, fwr}, 0);
        chk("R8 check word flag", {31'b0, lerr}, {31'b0, bad_ck});
        pkt = 0; data = '0; par = '0;
    endtask

    initial begin
        tick(); tick();
        rst_n = 1;
        chk("R2 reset conn", {31'b0, conn}, 0);
        chk("R4 reset rdy", {31'b0, rdy}, 0);
        chk("R6 reset wr", {31'b0, fwr}, 0);
        chk("R7 reset perr", {31'b0, perr}, 0);
        chk("R1 link high", {31'b0, link}, 1);

        // R1: self-test blocks grants
        stest = 1; #1;
        chk("R1 link low", {31'b0, link}, 0);
        req = 1; acc_en = 1; data = 32'h1234_5678;
        tick(); tick(); tick();
        chk("R1 no grant in self-test", {31'b0, conn}, 0);
        stest = 0; acc_en = 0;

        // R2: request without consent ignored
        data = 32'hDEAD_BEEF;
        tick(); tick();
        chk("R2 ignored conn", {31'b0, conn}, 0);
        chk("R2 ignored ifield", ifield, 32'h0);

        // R2 grant
        connect(32'hA5C3_0F96);
        chk("R2 grant conn", {31'b0, conn}, 1);
        chk("R2 ifield", ifield, 32'hA5C3_0F96);

        // R3 drop
        req = 0; tick();
        chk("R3 drop", {31'b0, conn}, 0);
        tick();

        // R4/R5 credit sweep over free room
        for (int s = 0; s < 8; s++) begin
            int c;
            free = FW'(s * SW + (s % SW));
            connect(32'h0);
            count_rdy(20, c);
            chk(s > MC ? "R5 credit ceiling" : "R4 credit count", c, (s < MC) ? s : MC);
            release_link();
        end

        // R6/R8/R10 good burst then returned credit
        begin
            int c;
            free = FW'(2 * SW);
            connect(32'h0);
            count_rdy(10, c);
            chk("R4 two slots", c, 2);
            burst(4, 32'h1357_9BDF, 1'b0);
            chk("R7 clean parity", {31'b0, perr}, 0);
            count_rdy(6, c);
            chk("R10 credit returned", c, 1);
            burst(3, 32'h2468_ACE0, 1'b1);
            tick(); tick();
            chk("R8 sticky", {31'b0, lerr}, 1);
            // R6: burst without packet frame is not written
            pkt = 0; bst = 1; data = 32'h7777_7777; tick();
            chk("R6 no write outside packet", {31'b0, fwr}, 0);
            bst = 0; tick();
            release_link();
        end

        // R7/R9 parity fault in each lane
        for (int k = 0; k < NB; k++) begin
            connect(32'h0);
            chk("R9 flags cleared", {30'b0, perr, lerr}, 0);
            pkt = 1; bst = 1;
            data = 32'h3C5A_96F1 + k;
            par = odd_par(data) ^ NB'(1 << k);
            tick();
            chk("R7 parity flag", {31'b0, perr}, 1);
            chk("R7 word still written", {31'b0, fwr}, 1);
            chk("R7 parity forwarded", {28'b0, fpar}, {28'b0, par});
            bst = 0; pkt = 0; par = '0; tick(); tick();
            chk("R7 parity sticky", {31'b0, perr}, 1);
            release_link();
        end

        // R1: self-test drops a live connection
        connect(32'h0);
        chk("R1 connected", {31'b0, conn}, 1);
        stest = 1; tick();
        chk("R1 drop on self-test", {31'b0, conn}, 0);
        stest = 0; req = 0; tick();

        $display("%0d/%0d checks passed", total - bad, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - bad, total);
        $finish;
    end
endmodule